// File: doc/BRIEF.md
# Exclusive Reservation Monitor with Data-Cache Allocation Path

This block holds the exclusive-access reservation of a single processor. It also models the part of a direct-mapped data cache that decides hits and allocates lines. A load-exclusive opens a reservation on one cache line. A later store-exclusive succeeds only while that reservation is still intact. The cache keeps one tag and one valid bit per set. A read that misses leaves one refill outstanding until the memory side answers.

Every refill writes a line into the cache, and every such write drops the reservation. This holds even when the answer is an external abort, in which case the line goes in marked invalid. A barrier waits for any outstanding read to finish. If that read aborts while the barrier waits between a load-exclusive and a store-exclusive, the reservation is lost and the store-exclusive fails. Software can then be caught in a retry loop that never makes progress.

Addresses on the ports are line addresses, with the byte offset already removed. The low `IDX_W` bits select the set, and the remaining upper bits form the tag.

Top module: `excl_monitor_cache`

## Requirements
- R1: After reset, no set holds a valid line and the monitor is open (`mon_excl`=0). `rd_hit`, `rd_pending`, `stx_done`, `stx_fail` and `bar_done` are all 0.
- R2: A load-exclusive makes `mon_excl` 1 in the next cycle and records the line given on `ex_line`, unless a store-exclusive is requested in the same cycle.
- R3: A store-exclusive pulses `stx_done` for one cycle, in the cycle after the request. With it, `stx_fail` reads 0 (success) only when the monitor was exclusive, the recorded line equals `ex_line`, and no allocation happens in the request cycle. Otherwise `stx_fail` reads 1, meaning failure and no write.
- R4: Any store-exclusive, whether it succeeds or fails, leaves the monitor open in the next cycle.
- R5: A read whose set is valid and whose tag matches pulses `rd_hit` in the next cycle. It allocates nothing and leaves `mon_excl` unchanged.
- R6: A read that misses while no read is outstanding raises `rd_pending` in the next cycle. While `rd_pending` is 1, further read requests are ignored.
- R7: A response with `mem_rsp_abort`=0 while a read is outstanding allocates the line as valid with its tag. A later read of that line hits.
- R8: A response with `mem_rsp_abort`=1 still allocates the set, replacing its old contents, but marks it invalid. A later read of either the aborted line or the line previously held in that set misses.
- R9: Every allocation, valid or invalid, opens the monitor in the next cycle unless a load-exclusive arrives in the same cycle. A response arriving while no read is outstanding is ignored.
- R10: A barrier pulses `bar_done` in the cycle after the first cycle, starting at the request, in which no read is outstanding or the outstanding read's response arrives. Until then `bar_done` stays 0.
- R11: On simultaneous requests, a store-exclusive takes precedence over a load-exclusive, which is ignored. A load-exclusive takes precedence over an allocation in the same cycle, so the reservation is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_req | input | 1 | Load-exclusive request |
| stx_req | input | 1 | Store-exclusive request |
| ex_line | input | ADDR_W-OFF_W | Line address of the exclusive access |
| rd_req | input | 1 | Cacheable read request |
| rd_line | input | ADDR_W-OFF_W | Line address of the read |
| mem_rsp_valid | input | 1 | Refill response for the outstanding read |
| mem_rsp_abort | input | 1 | Response is an external abort |
| bar_req | input | 1 | Barrier request |
| rd_hit | output | 1 | Read hit pulse |
| rd_pending | output | 1 | A missed read awaits its response |
| stx_done | output | 1 | Store-exclusive result strobe |
| stx_fail | output | 1 | Store-exclusive status, 0 success, 1 failure |
| bar_done | output | 1 | Barrier completion pulse |
| mon_excl | output | 1 | Monitor is in the exclusive state |

## Verification
On every cycle the assertions check the local monitor transitions: a load-exclusive sets the monitor, a store-exclusive opens it, and an allocation clears it. They also check that a store-exclusive on an open monitor fails, that a pending read stays pending until its response arrives, and that a barrier issued over an unanswered read does not complete in the next cycle. Only the bench scenarios can show the effects that span many cycles. These are a reservation lost to an aborted refill that finishes while a barrier waits, an aborted refill evicting an earlier valid line, line-granular address comparison, and same-cycle priority between requests.

// File: rtl/excl_monitor_cache.sv
module excl_monitor_cache #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ldx_req,
  input  logic                    stx_req,
  input  logic [ADDR_W-OFF_W-1:0] ex_line,
  input  logic                    rd_req,
  input  logic [ADDR_W-OFF_W-1:0] rd_line,
  input  logic                    mem_rsp_valid,
  input  logic                    mem_rsp_abort,
  input  logic                    bar_req,
  output logic                    rd_hit,
  output logic                    rd_pending,
  output logic                    stx_done,
  output logic                    stx_fail,
  output logic                    bar_done,
  output logic                    mon_excl
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int SETS   = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic              pend_q;
  logic [LINE_W-1:0] pend_line_q;
  logic              excl_q;
  logic [LINE_W-1:0] resv_q;
  logic              bar_wait_q;
  logic              hit_q, sdone_q, sfail_q, bdone_q;

  logic [IDX_W-1:0]  rd_idx, fill_idx;
  logic [TAG_W-1:0]  rd_tag, fill_tag;
  logic              lookup_hit, rd_take, fill, stx_ok, bar_act, bar_fin;

  assign rd_idx     = rd_line[IDX_W-1:0];
  assign rd_tag     = rd_line[LINE_W-1:IDX_W];
  assign fill_idx   = pend_line_q[IDX_W-1:0];
  assign fill_tag   = pend_line_q[LINE_W-1:IDX_W];
  assign lookup_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_take    = rd_req && !pend_q;
  assign fill       = mem_rsp_valid && pend_q;
  assign stx_ok     = excl_q && (resv_q == ex_line) && !fill;
  assign bar_act    = bar_req || bar_wait_q;
  assign bar_fin    = bar_act && (!pend_q || fill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      pend_q      <= 1'b0;
      pend_line_q <= '0;
      excl_q      <= 1'b0;
      resv_q      <= '0;
      bar_wait_q  <= 1'b0;
      hit_q       <= 1'b0;
      sdone_q     <= 1'b0;
      sfail_q     <= 1'b0;
      bdone_q     <= 1'b0;
    end else begin
      hit_q      <= rd_take && lookup_hit;
      sdone_q    <= stx_req;
      sfail_q    <= stx_req && !stx_ok;
      bdone_q    <= bar_fin;
      bar_wait_q <= bar_act && !bar_fin;

      if (fill) begin
        valid_q[fill_idx] <= !mem_rsp_abort;
        pend_q            <= 1'b0;
      end else if (rd_take && !lookup_hit) begin
        pend_q      <= 1'b1;
        pend_line_q <= rd_line;
      end

      if (stx_req) begin
        excl_q <= 1'b0;
      end else if (ldx_req) begin
        excl_q <= 1'b1;
        resv_q <= ex_line;
      end else if (fill) begin
        excl_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_hit     = hit_q;
  assign rd_pending = pend_q;
  assign stx_done   = sdone_q;
  assign stx_fail   = sfail_q;
  assign bar_done   = bdone_q;
  assign mon_excl   = excl_q;

  p_ldx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_req && !stx_req |=> mon_excl);
  p_open_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stx_req && !mon_excl |=> stx_done && stx_fail);
  p_stx_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stx_req |=> !mon_excl);
  p_hit_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !rd_pending);
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending && !mem_rsp_valid |=> rd_pending);
  p_alloc_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending && mem_rsp_valid && !ldx_req |=> !mon_excl && !rd_pending);
  p_bar_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_req && rd_pending && !mem_rsp_valid |=> !bar_done);
endmodule

// File: tb/tb_excl_monitor_cache.sv
module tb_excl_monitor_cache;
  localparam int LW = 27;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ldx_req = 0, stx_req = 0, rd_req = 0, mem_rsp_valid = 0, mem_rsp_abort = 0, bar_req = 0;
  logic [LW-1:0] ex_line = '0, rd_line = '0;
  logic rd_hit, rd_pending, stx_done, stx_fail, bar_done, mon_excl;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  excl_monitor_cache dut (
    .clk(clk), .rst_n(rst_n), .ldx_req(ldx_req), .stx_req(stx_req), .ex_line(ex_line),
    .rd_req(rd_req), .rd_line(rd_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_abort(mem_rsp_abort), .bar_req(bar_req), .rd_hit(rd_hit),
    .rd_pending(rd_pending), .stx_done(stx_done), .stx_fail(stx_fail),
    .bar_done(bar_done), .mon_excl(mon_excl));

  logic m_valid [16];
  logic [22:0] m_tag [16];
  logic m_pend, m_excl, m_barw;
  logic [LW-1:0] m_pline, m_resv;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_lookup(input logic [LW-1:0] l);
    return m_valid[l[3:0]] && (m_tag[l[3:0]] == l[26:4]);
  endfunction

  task automatic step(input logic ldx, input logic stx, input logic [LW-1:0] el,
                      input logic rd, input logic [LW-1:0] rl,
                      input logic rv, input logic rab, input logic br);
    logic e_hit, fill, e_sf, bact, bfin;
    string mtag;
    ldx_req = ldx; stx_req = stx; ex_line = el; rd_req = rd; rd_line = rl;
    mem_rsp_valid = rv; mem_rsp_abort = rab; bar_req = br;
    e_hit = rd && !m_pend && m_lookup(rl);
    fill  = rv && m_pend;
    e_sf  = !(m_excl && m_resv == el && !fill);
    bact  = br || m_barw;
    bfin  = bact && (!m_pend || fill);
    m_barw = bact && !bfin;
    mtag = stx ? "R4/R11" : ldx ? "R2" : fill ? "R9" : "R5";
    if (fill) begin
      m_valid[m_pline[3:0]] = !rab;
      m_tag[m_pline[3:0]]   = m_pline[26:4];
      m_pend = 1'b0;
    end else if (rd && !m_pend && !e_hit) begin
      m_pend = 1'b1;
      m_pline = rl;
    end
    if (stx) m_excl = 1'b0;
    else if (ldx) begin m_excl = 1'b1; m_resv = el; end
    else if (fill) m_excl = 1'b0;
    @(posedge clk); @(negedge clk);
    ldx_req = 0; stx_req = 0; rd_req = 0; mem_rsp_valid = 0; mem_rsp_abort = 0; bar_req = 0;
    chk("R5 rd_hit", rd_hit, e_hit);
    chk("R6 rd_pending", rd_pending, m_pend);
    chk("R3 stx_done", stx_done, stx);
    chk("R3 stx_fail", stx_fail, stx && e_sf);
    chk("R10 bar_done", bar_done, bfin);
    chk({mtag, " mon_excl"}, mon_excl, m_excl);
  endtask

  task automatic idle();
    step(0, 0, '0, 0, '0, 0, 0, 0);
  endtask

  function automatic logic [LW-1:0] mk(input int t, input int i);
    return {23'(t), 4'(i)};
  endfunction

  initial begin
    logic [LW-1:0] la, lb, lc, ld;
    void'($urandom(1234));
    for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
    m_pend = 0; m_excl = 0; m_barw = 0; m_pline = '0; m_resv = '0;
    la = mk(5, 1); lb = mk(6, 1); lc = mk(9, 2); ld = mk(3, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 mon_excl", mon_excl, 0);
    chk("R1 rd_pending", rd_pending, 0);
    chk("R1 stx_done", stx_done, 0);
    chk("R1 bar_done", bar_done, 0);
    step(0, 0, '0, 1, la, 0, 0, 0);
    chk("R1 cold miss", rd_hit, 0);
    chk("R6 miss pends", rd_pending, 1);
    step(0, 0, '0, 1, lc, 0, 0, 0);
    chk("R6 ignored while pending", rd_hit, 0);
    step(0, 0, '0, 0, '0, 1, 0, 0);
    step(0, 0, '0, 1, la, 0, 0, 0);
    chk("R7 hit after fill", rd_hit, 1);
    step(1, 0, la, 0, '0, 0, 0, 0);
    chk("R2 set", mon_excl, 1);
    step(0, 1, la, 0, '0, 0, 0, 0);
    chk("R3 success", stx_fail, 0);
    chk("R4 open", mon_excl, 0);
    step(0, 1, la, 0, '0, 0, 0, 0);
    chk("R3 open fails", stx_fail, 1);
    step(1, 0, la, 0, '0, 0, 0, 0);
    step(0, 0, '0, 1, la, 0, 0, 0);
    chk("R5 hit keeps", mon_excl, 1);
    step(0, 1, la + 27'(16), 0, '0, 0, 0, 0);
    chk("R3 other line fails", stx_fail, 1);
    step(1, 0, la, 0, '0, 0, 0, 0);
    step(0, 0, '0, 1, lc, 0, 0, 0);
    step(0, 0, '0, 0, '0, 0, 0, 1);
    chk("R10 waits", bar_done, 0);
    idle();
    chk("R10 still waits", bar_done, 0);
    step(0, 0, '0, 0, '0, 1, 1, 0);
    chk("R10 done after abort", bar_done, 1);
    chk("R9 abort clears", mon_excl, 0);
    step(0, 1, la, 0, '0, 0, 0, 0);
    chk("R9 stx fails", stx_fail, 1);
    step(0, 0, '0, 1, lc, 0, 0, 0);
    chk("R8 aborted line misses", rd_hit, 0);
    step(0, 0, '0, 0, '0, 1, 0, 0);
    step(0, 0, '0, 1, lb, 0, 0, 0);
    step(0, 0, '0, 0, '0, 1, 1, 0);
    step(0, 0, '0, 1, la, 0, 0, 0);
    chk("R8 evicted line misses", rd_hit, 0);
    step(0, 0, '0, 0, '0, 0, 0, 0);
    step(0, 0, '0, 0, '0, 1, 0, 0);
    step(0, 0, '0, 0, '0, 1, 0, 0);
    chk("R9 stray response ignored", rd_pending, 0);
    step(1, 1, la, 0, '0, 0, 0, 0);
    chk("R11 stx over ldx", mon_excl, 0);
    step(0, 0, '0, 1, ld, 0, 0, 0);
    step(1, 0, la, 0, '0, 1, 0, 0);
    chk("R11 ldx over alloc", mon_excl, 1);
    step(0, 0, '0, 0, '0, 0, 0, 1);
    chk("R10 idle barrier", bar_done, 1);
    for (int n = 0; n < 4000; n++) begin
      logic [LW-1:0] re, rr;
      logic pl, ps, pr, pv, pa, pb;
      re = mk($urandom_range(0, 2), $urandom_range(0, 3));
      rr = mk($urandom_range(0, 2), $urandom_range(0, 3));
      pl = ($urandom_range(0, 9) == 0);
      ps = ($urandom_range(0, 9) == 0);
      pr = ($urandom_range(0, 2) == 0);
      pv = ($urandom_range(0, 3) == 0);
      pa = ($urandom_range(0, 2) == 0);
      pb = ($urandom_range(0, 11) == 0);
      step(pl, ps, re, pr, rr, pv, pa, pb);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule